// File: doc/BRIEF.md
# Sign-Extending Immediate Logic and Shift ALU

This block is the execution slice of a 16-bit register-stack processor that handles three operations. Two of them are AND operations with an 8-bit immediate. The third is a signed right shift. The processor's decoder supplies the operation, the 8-bit immediate or count field, and the two top-of-stack registers, A and B. The block returns the new value for A, a pop request and a two-bit condition code made of a negative flag and a zero flag.

The first AND form places the immediate in the upper byte and fills the lower byte with copies of the immediate's top bit. The second AND form sign-extends the immediate into the upper byte. The shift has two count sources. A nonzero count field shifts A by that field. A zero count field shifts B by the value held in A, and the block then asks the stack to drop A.

The core is combinational. A parameter chooses whether a register stage follows it.

Top module: `imm_shift_alu`

## Requirements
- R1: With opSel = 2'b00 the result is A AND {imm, eight copies of imm[7]}, and no pop is requested.
- R2: With opSel = 2'b01 the result is A AND {eight copies of imm[7], imm}, and no pop is requested.
- R3: With opSel = 2'b10 and a count field from 1 to 15, the result is A shifted right by the field with the sign bit filling in, and no pop is requested.
- R4: With opSel = 2'b10 and a count field from 16 to 31, the result is 16 copies of A[15].
- R5: With opSel = 2'b10 and a count field of zero, the result is B shifted right with sign fill by the count held in A (0 to 15), and popReq is asserted.
- R6: A dynamic count held in A from 16 to 31 gives 16 copies of B[15]. Counts outside 0 to 31 give an unspecified result.
- R7: ccNeg equals bit 15 of every delivered result.
- R8: ccZero is set exactly when a delivered result is zero.
- R9: When opValid is low, or when opSel = 2'b11, nothing is delivered: resValid and popReq are low, and resA, ccNeg and ccZero keep their previous values.
- R10: With REG_OUT = 1 each result appears on the cycle after its inputs, and reset clears resValid, popReq, resA, ccNeg and ccZero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented |
| opSel | input | 2 | 00 AND-high, 01 AND-low, 10 signed shift, 11 reserved |
| fieldIn | input | 8 | Immediate byte or static shift count |
| regA | input | 16 | Top-of-stack register A |
| regB | input | 16 | Second stack register B |
| resValid | output | 1 | resA and the flags carry a new result |
| resA | output | 16 | New value for A |
| popReq | output | 1 | Drop A from the stack (dynamic shift only) |
| ccNeg | output | 1 | Negative flag |
| ccZero | output | 1 | Zero flag |

## Verification
The assertions assume that opValid and opSel are held at known values while reset is active, with opValid low. The latency and hold properties are armed only after one clean cycle out of reset. They also take it that every delivered AND result comes from the A value presented one cycle earlier. The stimulus drives a dynamic count only from 0 to 31, because the result for larger or negative counts is unspecified. Any out-of-range count that does occur is not checked against an expected value.

// File: rtl/isa_alu_pkg.sv
package isa_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND_HI = 2'b00,
    OP_AND_LO = 2'b01,
    OP_SHR    = 2'b10,
    OP_RSVD   = 2'b11
  } opSel_e;

  typedef struct packed {
    logic fire;
    logic andHigh;
    logic isShift;
    logic dynCount;
  } aluCtl_t;
endpackage

// File: rtl/imm_shift_ctl.sv
module imm_shift_ctl
  import isa_alu_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic             opValid,
  input  logic [1:0]       opSel,
  input  logic [IMM_W-1:0] fieldIn,
  output aluCtl_t          ctl
);
  opSel_e op;
  assign op = opSel_e'(opSel);

  always_comb begin
    ctl = '0;
    if (opValid) begin
      case (op)
        OP_AND_HI: begin ctl.fire = 1'b1; ctl.andHigh = 1'b1; end
        OP_AND_LO: ctl.fire = 1'b1;
        OP_SHR: begin
          ctl.fire     = 1'b1;
          ctl.isShift  = 1'b1;
          ctl.dynCount = (fieldIn == '0);
        end
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/imm_shift_dp.sv
module imm_shift_dp
  import isa_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic [IMM_W-1:0]  immIn,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  output logic              resValid,
  output logic [DATA_W-1:0] resA,
  output logic              popReq,
  output logic              ccNeg,
  output logic              ccZero
);
  localparam int FILL_W = DATA_W - IMM_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] CNT_LIMIT = DATA_W'(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hiMask, loMask, andRes;
  logic [DATA_W-1:0] rawCnt, shSrc, shRes, nextRes;
  logic [CNT_W-1:0]  shAmt;
  logic              nextPop;

  assign hiMask = {immIn, {FILL_W{immIn[IMM_W-1]}}};
  assign loMask = {{FILL_W{immIn[IMM_W-1]}}, immIn};
  assign andRes = regA & (ctl.andHigh ? hiMask : loMask);

  assign rawCnt = ctl.dynCount ? regA : DATA_W'(immIn);
  assign shSrc  = ctl.dynCount ? regB : regA;
  assign shAmt  = (rawCnt >= CNT_LIMIT) ? CNT_MAX : rawCnt[CNT_W-1:0];
  assign shRes  = DATA_W'($signed(shSrc) >>> shAmt);

  assign nextRes = ctl.isShift ? shRes : andRes;
  assign nextPop = ctl.fire & ctl.dynCount;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          resValid <= 1'b0;
          popReq   <= 1'b0;
          resA     <= '0;
          ccNeg    <= 1'b0;
          ccZero   <= 1'b0;
        end else begin
          resValid <= ctl.fire;
          popReq   <= nextPop;
          if (ctl.fire) begin
            resA   <= nextRes;
            ccNeg  <= nextRes[DATA_W-1];
            ccZero <= (nextRes == '0);
          end
        end
      end
    end else begin : g_comb
      assign resValid = ctl.fire;
      assign popReq   = nextPop;
      assign resA     = ctl.fire ? nextRes : regA;
      assign ccNeg    = ctl.fire & nextRes[DATA_W-1];
      assign ccZero   = ctl.fire & (nextRes == '0);
    end
  endgenerate
endmodule

// File: rtl/imm_shift_alu.sv
module imm_shift_alu
  import isa_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [IMM_W-1:0]  fieldIn,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  output logic              resValid,
  output logic [DATA_W-1:0] resA,
  output logic              popReq,
  output logic              ccNeg,
  output logic              ccZero
);
  aluCtl_t ctl;

  imm_shift_ctl #(.IMM_W(IMM_W)) ctl_i (
    .opValid(opValid), .opSel(opSel), .fieldIn(fieldIn), .ctl(ctl)
  );

  imm_shift_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immIn(fieldIn),
    .regA(regA), .regB(regB), .resValid(resValid), .resA(resA),
    .popReq(popReq), .ccNeg(ccNeg), .ccZero(ccZero)
  );
endmodule

// File: rtl/imm_shift_alu_chk.sv
module imm_shift_alu_chk #(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opSel,
  input logic [IMM_W-1:0]  fieldIn,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic              resValid,
  input logic [DATA_W-1:0] resA,
  input logic              popReq,
  input logic              ccNeg,
  input logic              ccZero
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_seq
      assert_pop_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
        popReq |-> resValid);
      assert_neg_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
        resValid |-> (ccNeg == resA[DATA_W-1]));
      assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
        resValid |-> (ccZero == (resA == '0)));
      assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
        armed |-> (resValid == $past(opValid && (opSel != 2'b11))));
      assert_and_subset_R1: assert property (@(posedge clk) disable iff (!rstN)
        (armed && resValid && ($past(opSel) == 2'b00)) |-> ((resA & ~$past(regA)) == '0));
      assert_pop_dyn_only_R5: assert property (@(posedge clk) disable iff (!rstN)
        (armed && popReq) |-> (($past(opSel) == 2'b10) && ($past(fieldIn) == '0)));
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        (armed && !$past(opValid && (opSel != 2'b11))) |-> ($stable(resA) && !resValid && !popReq));
    end else begin : g_imm
      always_comb begin
        if (rstN) begin
          assert_pop_valid_R5: assert (!popReq || resValid);
          assert_neg_msb_R7: assert (!resValid || (ccNeg == resA[DATA_W-1]));
          assert_zero_flag_R8: assert (!resValid || (ccZero == (resA == '0)));
          assert_idle_R9: assert (opValid || !resValid);
        end
      end
    end
  endgenerate
endmodule

bind imm_shift_alu imm_shift_alu_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)
) chk_i (.*);

// File: tb/imm_shift_alu_tb.sv
module imm_shift_alu_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [1:0]  opSel;
  logic [7:0]  fieldIn;
  logic [15:0] regA, regB;
  logic        resValid, popReq, ccNeg, ccZero;
  logic [15:0] resA;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  imm_shift_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .fieldIn(fieldIn), .regA(regA), .regB(regB), .resValid(resValid),
    .resA(resA), .popReq(popReq), .ccNeg(ccNeg), .ccZero(ccZero)
  );

  logic [15:0] aSet [6] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h1234};

  function automatic logic [15:0] sraRef(logic [15:0] v, int n);
    logic [15:0] r = v;
    for (int k = 0; k < n; k++) r = {r[15], r[15:1]};
    return r;
  endfunction

  task automatic check(string req, logic [15:0] expRes, logic expPop);
    logic expNeg, expZero;
    expNeg  = expRes[15];
    expZero = (expRes == 16'h0000);
    vecCount++;
    if (resValid !== 1'b1 || resA !== expRes || popReq !== expPop ||
        ccNeg !== expNeg || ccZero !== expZero) begin
      errCount++;
      $display("FAIL %s: got v=%b res=%h pop=%b n=%b z=%b, expected v=1 res=%h pop=%b n=%b z=%b",
               req, resValid, resA, popReq, ccNeg, ccZero, expRes, expPop, expNeg, expZero);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [7:0] f, logic [15:0] a, logic [15:0] b);
    opValid = 1'b1; opSel = op; fieldIn = f; regA = a; regB = b;
    @(negedge clk);
  endtask

  task automatic checkIdle(string req, logic [15:0] heldRes);
    vecCount++;
    if (resValid !== 1'b0 || popReq !== 1'b0 || resA !== heldRes) begin
      errCount++;
      $display("FAIL %s: got v=%b pop=%b res=%h, expected v=0 pop=0 res=%h",
               req, resValid, popReq, resA, heldRes);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rstN = 1'b0; opValid = 1'b0; opSel = 2'b00; fieldIn = 8'h00; regA = '0; regB = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    vecCount++;
    if (resValid !== 1'b0 || popReq !== 1'b0 || resA !== 16'h0 || ccNeg !== 1'b0 || ccZero !== 1'b0) begin
      errCount++;
      $display("FAIL R10: got v=%b pop=%b res=%h n=%b z=%b, expected all zero",
               resValid, popReq, resA, ccNeg, ccZero);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2, R7, R8: every immediate against a set of A values
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [7:0] imm;
        imm = 8'(i);
        apply(2'b00, imm, aSet[j], 16'hDEAD);
        check("R1", aSet[j] & {imm, {8{imm[7]}}}, 1'b0);
        apply(2'b01, imm, aSet[j], 16'hBEEF);
        check("R2", aSet[j] & {{8{imm[7]}}, imm}, 1'b0);
      end
    end

    // R3, R4: static count from the field
    for (int c = 1; c < 32; c++) begin
      for (int j = 0; j < 6; j++) begin
        apply(2'b10, 8'(c), aSet[j], 16'h5555);
        if (c < 16) check("R3", sraRef(aSet[j], c), 1'b0);
        else        check("R4", {16{aSet[j][15]}}, 1'b0);
      end
    end

    // R5, R6: dynamic count from A, shift B, pop
    for (int c = 0; c < 32; c++) begin
      for (int j = 0; j < 6; j++) begin
        apply(2'b10, 8'h00, 16'(c), aSet[j]);
        if (c < 16) check("R5", sraRef(aSet[j], c), 1'b1);
        else        check("R6", {16{aSet[j][15]}}, 1'b1);
      end
    end

    // R9: idle and reserved code hold the result
    apply(2'b01, 8'h0F, 16'h00F3, 16'h0);
    check("R9", 16'h0003, 1'b0);
    held = 16'h0003;
    opValid = 1'b0; opSel = 2'b10; fieldIn = 8'h00; regA = 16'h0001; regB = 16'h8000;
    @(negedge clk);
    checkIdle("R9", held);
    opValid = 1'b1; opSel = 2'b11; fieldIn = 8'h00; regA = 16'hFFFF;
    @(negedge clk);
    checkIdle("R9", held);
    vecCount++;
    if (ccNeg !== 1'b0 || ccZero !== 1'b0) begin
      errCount++;
      $display("FAIL R9: got n=%b z=%b, expected n=0 z=0", ccNeg, ccZero);
    end
    opValid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule